// File: doc/BRIEF.md
# Serial Flash Sector Write Controller

This block is the serial front end and commit logic for a page-write command of a small serial flash. A host clocks a frame into it over a four-wire SPI link in mode 0. The frame carries an 8-bit command code, a 16-bit sector field, a 16-bit starting column field and then any number of data bytes. The data bytes go into a 264-byte page buffer at a column that advances by one after each byte and wraps back to zero after the last column.

When chip select returns high on a byte boundary after the address fields are complete, the block checks three things: the write-protect pin, a write-enable latch that was set before the frame, and a protected sector window. If all three allow the write, the block runs a program cycle that lasts a fixed number of system clocks. During that cycle it reports busy and streams the whole page buffer, one byte per clock, onto a synchronous array write port. SPI signals are oversampled by the system clock, so the serial clock must run well below the system clock.

Top module: `sector_write_ctrl`

## Requirements
- R1: A frame starts when spi_cs_n falls. Bits are sampled on each rising spi_sclk while spi_cs_n is low, most significant bit first. The first byte must be F3h. Any other first byte makes the block ignore the rest of the frame, so the buffer, the latch and the array stay unchanged.
- R2: The 16-bit sector field arrives high byte first. Only its low SEC_BITS bits select the sector, and the bits above them are ignored.
- R3: The 16-bit column field arrives high byte first. Only its low 9 bits are used. A value above 107h aborts the frame: no buffer write and no program cycle.
- R4: Data bytes are stored at ascending columns starting at the column field. Column 107h is followed by column 0. Columns that are not written keep their previous contents, and bytes are stored whether or not the later commit is allowed.
- R5: The last complete byte received before spi_cs_n rises is a control byte and is never stored.
- R6: spi_cs_n rising before the column field is complete, or in the middle of a byte, discards the frame without a program cycle.
- R7: A frame that ends correctly starts a program cycle only if wp_n is high, wel is set and the sector lies outside the inclusive window prot_lo..prot_hi. Otherwise nothing is programmed.
- R8: A one-cycle wel_set pulse sets wel while busy is low and is ignored while busy is high. Starting a program cycle clears wel. A rejected frame leaves wel as it was.
- R9: A program cycle raises busy from the clock edge that sees spi_cs_n high, for exactly PROG_CYCLES clocks. During its first 264 clocks, arr_we is high and arr_col counts up from 0, with arr_data carrying that buffer byte and arr_sector carrying the frame's sector.
- R10: A frame whose spi_cs_n falls while busy is high is ignored completely: no buffer write and no further program cycle.
- R11: After reset, busy, wel and arr_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, high allows writes |
| wel_set | input | 1 | Pulse that sets the write-enable latch |
| prot_lo | input | SEC_BITS | First sector of the protected window |
| prot_hi | input | SEC_BITS | Last sector of the protected window |
| busy | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable latch |
| arr_we | output | 1 | Array byte write strobe |
| arr_sector | output | SEC_BITS | Sector being programmed |
| arr_col | output | 9 | Column being programmed |
| arr_data | output | 8 | Byte being programmed |

## Verification
The assertions check the rules of the program cycle on every clock. The write strobe appears only while busy is high. Columns rise by one per clock starting at zero, and the sector stays fixed for the whole cycle. A cycle can start only after a set latch and a high protect pin, it clears the latch, and busy lasts exactly the programmed length. Framing is checked only by the bench scenarios: opcode filtering, field truncation, column wrap, dropping the control byte, aborts in the middle of a byte or the address, the protected window, and frames ignored while busy. Each of these shows up only in the page contents captured from the array port.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam logic [7:0] OPC_SECTOR_WRITE = 8'hF3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_SEC_HI,
        PH_SEC_LO,
        PH_COL_HI,
        PH_COL_LO,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } byte_evt_t;

    // next column with wrap at the page end
    function automatic int unsigned col_next(input int unsigned col, input int unsigned depth);
        return (col + 1 >= depth) ? 0 : col + 1;
    endfunction

endpackage

// File: rtl/swc_shifter.sv
module swc_shifter
    import swc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk,
    input  logic      cs_n,
    input  logic      mosi,
    output byte_evt_t evt,
    output logic      cs_fall,
    output logic      cs_rise,
    output logic      mid_byte
);
    logic       sclk_q;
    logic       cs_q;
    logic [6:0] sh;
    logic [2:0] bit_cnt;
    logic       sclk_rise;

    assign sclk_rise = sclk & ~sclk_q & ~cs_n;
    assign cs_fall   = ~cs_n & cs_q;
    assign cs_rise   = cs_n & ~cs_q;
    assign mid_byte  = (bit_cnt != 3'd0);
    assign evt.vld   = sclk_rise && (bit_cnt == 3'd7);
    assign evt.data  = {sh, mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            sh      <= '0;
            bit_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (cs_fall) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                sh      <= {sh[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
            end
        end
    end
endmodule

// File: rtl/swc_page_buf.sv
module swc_page_buf #(
    parameter int unsigned DEPTH = 264,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/swc_prog_seq.sv
module swc_prog_seq #(
    parameter int unsigned PAGE_BYTES  = 264,
    parameter int unsigned PROG_CYCLES = 300,
    parameter int unsigned SEC_BITS    = 9,
    parameter int unsigned COL_W       = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SEC_BITS-1:0] start_sector,
    output logic                busy,
    output logic                arr_we,
    output logic [SEC_BITS-1:0] arr_sector,
    output logic [COL_W-1:0]    arr_col
);
    localparam int unsigned CNT_W = $clog2(PROG_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cnt        <= '0;
            arr_sector <= '0;
        end else if (busy) begin
            if (cnt == CNT_LAST) busy <= 1'b0;
            cnt <= cnt + CNT_W'(1);
        end else if (start) begin
            busy       <= 1'b1;
            cnt        <= '0;
            arr_sector <= start_sector;
        end
    end

    assign arr_we  = busy && (32'(cnt) < PAGE_BYTES);
    assign arr_col = COL_W'(cnt);
endmodule

// File: rtl/sector_write_ctrl.sv
module sector_write_ctrl
    import swc_pkg::*;
#(
    parameter int unsigned SEC_BITS    = 9,
    parameter int unsigned PAGE_BYTES  = 264,
    parameter int unsigned PROG_CYCLES = 300
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_sclk,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    input  logic                wp_n,
    input  logic                wel_set,
    input  logic [SEC_BITS-1:0] prot_lo,
    input  logic [SEC_BITS-1:0] prot_hi,
    output logic                busy,
    output logic                wel,
    output logic                arr_we,
    output logic [SEC_BITS-1:0] arr_sector,
    output logic [8:0]          arr_col,
    output logic [7:0]          arr_data
);
    localparam int unsigned COL_W = $clog2(PAGE_BYTES);

    byte_evt_t           evt;
    logic                cs_fall, cs_rise, mid_byte;
    phase_e              ph;
    logic [7:0]          hi_byte;
    logic [15:0]         field;
    logic [SEC_BITS-1:0] sec_r;
    logic [COL_W-1:0]    col_r;
    logic [7:0]          pend;
    logic                pend_vld;
    logic                wel_r;
    logic                sec_prot;
    logic                commit;
    logic                buf_we;
    logic [COL_W-1:0]    rd_col;

    swc_shifter u_shift (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .evt(evt), .cs_fall(cs_fall), .cs_rise(cs_rise), .mid_byte(mid_byte)
    );

    assign field    = {hi_byte, evt.data};
    assign sec_prot = (sec_r >= prot_lo) && (sec_r <= prot_hi);
    assign commit   = cs_rise && (ph == PH_DATA) && !mid_byte && wp_n && wel_r && !sec_prot;
    assign buf_we   = evt.vld && (ph == PH_DATA) && pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            hi_byte  <= '0;
            sec_r    <= '0;
            col_r    <= '0;
            pend     <= '0;
            pend_vld <= 1'b0;
        end else if (cs_fall) begin
            ph       <= busy ? PH_SKIP : PH_OPC;
            pend_vld <= 1'b0;
        end else if (cs_rise) begin
            ph <= PH_IDLE;
        end else if (evt.vld) begin
            unique case (ph)
                PH_OPC:    ph <= (evt.data == OPC_SECTOR_WRITE) ? PH_SEC_HI : PH_SKIP;
                PH_SEC_HI: begin hi_byte <= evt.data; ph <= PH_SEC_LO; end
                PH_SEC_LO: begin sec_r <= field[SEC_BITS-1:0]; ph <= PH_COL_HI; end
                PH_COL_HI: begin hi_byte <= evt.data; ph <= PH_COL_LO; end
                PH_COL_LO: begin
                    col_r <= field[COL_W-1:0];
                    ph    <= (32'(field[COL_W-1:0]) < PAGE_BYTES) ? PH_DATA : PH_SKIP;
                end
                PH_DATA: begin
                    if (pend_vld) col_r <= COL_W'(col_next(32'(col_r), PAGE_BYTES));
                    pend     <= evt.data;
                    pend_vld <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      wel_r <= 1'b0;
        else if (commit)              wel_r <= 1'b0;
        else if (wel_set && !busy)    wel_r <= 1'b1;
    end

    swc_page_buf #(.DEPTH(PAGE_BYTES), .AW(COL_W)) u_buf (
        .clk(clk), .we(buf_we), .waddr(col_r), .wdata(pend),
        .raddr(rd_col), .rdata(arr_data)
    );

    swc_prog_seq #(
        .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES),
        .SEC_BITS(SEC_BITS), .COL_W(COL_W)
    ) u_prog (
        .clk(clk), .rst(rst), .start(commit), .start_sector(sec_r),
        .busy(busy), .arr_we(arr_we), .arr_sector(arr_sector), .arr_col(rd_col)
    );

    assign wel     = wel_r;
    assign arr_col = 9'(rd_col);
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
    parameter int unsigned SEC_BITS    = 9,
    parameter int unsigned PAGE_BYTES  = 264,
    parameter int unsigned PROG_CYCLES = 300
) (
    input logic                clk,
    input logic                rst,
    input logic                wp_n,
    input logic                busy,
    input logic                wel,
    input logic                arr_we,
    input logic [SEC_BITS-1:0] arr_sector,
    input logic [8:0]          arr_col
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_we_inside_busy_R9: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    assert_col_in_page_R9: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (32'(arr_col) < PAGE_BYTES));

    assert_col_step_R9: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_col == $past(arr_col) + 9'd1));

    assert_start_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (arr_we && arr_col == 9'd0));

    assert_sector_held_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(arr_sector));

    assert_busy_not_long_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < PROG_CYCLES));

    assert_busy_exact_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == PROG_CYCLES));

    assert_start_needs_wel_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));

    assert_start_needs_pin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wp_n));

    assert_wel_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !wel);
endmodule

bind sector_write_ctrl swc_checker #(
    .SEC_BITS(SEC_BITS), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_swc_checker (
    .clk(clk), .rst(rst), .wp_n(wp_n), .busy(busy), .wel(wel),
    .arr_we(arr_we), .arr_sector(arr_sector), .arr_col(arr_col)
);

// File: tb/sector_write_ctrl_bench.sv
module sector_write_ctrl_bench;
    localparam int PAGE = 264;
    localparam int PROG = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       wp_n = 1'b1, wel_set = 1'b0;
    logic [8:0] prot_lo = 9'h1FF, prot_hi = 9'h000;
    logic       busy, wel, arr_we;
    logic [8:0] arr_sector, arr_col;
    logic [7:0] arr_data;

    always #4 clk = ~clk;

    sector_write_ctrl u_sector_write_ctrl (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .wp_n(wp_n), .wel_set(wel_set), .prot_lo(prot_lo), .prot_hi(prot_hi),
        .busy(busy), .wel(wel), .arr_we(arr_we), .arr_sector(arr_sector),
        .arr_col(arr_col), .arr_data(arr_data)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    logic [7:0] cap  [PAGE];
    logic [7:0] ebuf [PAGE];
    logic [7:0] tx   [300];
    int we_tot = 0, busy_tot = 0, cap_sec = 0;

    always @(negedge clk) begin
        if (arr_we) begin
            cap[arr_col] = arr_data;
            cap_sec      = int'(arr_sector);
            we_tot++;
        end
        if (busy) busy_tot++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        @(negedge clk); mosi = b; sclk = 1'b0;
        ticks(2); sclk = 1'b1;
        ticks(1);
    endtask

    task automatic spi_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_bit(b[i]);
    endtask

    task automatic frame(input logic [7:0] opc, input logic [15:0] sec, input logic [15:0] col,
                         input int nhdr, input int ndata, input bit ctrl, input int xbits);
        logic [7:0] hdr [5];
        hdr[0] = opc; hdr[1] = sec[15:8]; hdr[2] = sec[7:0]; hdr[3] = col[15:8]; hdr[4] = col[7:0];
        @(negedge clk); cs_n = 1'b0;
        ticks(2);
        for (int k = 0; k < nhdr; k++) spi_byte(hdr[k]);
        for (int k = 0; k < ndata; k++) spi_byte(tx[k]);
        if (ctrl) spi_byte(8'h00);
        for (int k = 0; k < xbits; k++) spi_bit(1'b0);
        @(negedge clk); sclk = 1'b0;
        ticks(2); cs_n = 1'b1;
        ticks(2);
    endtask

    task automatic model_load(input int col, input int ndata);
        int c = col;
        for (int i = 0; i < ndata; i++) begin
            ebuf[c] = tx[i];
            c = (c == PAGE - 1) ? 0 : c + 1;
        end
    endtask

    task automatic pulse_wel();
        @(negedge clk); wel_set = 1'b1;
        @(negedge clk); wel_set = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic check_program(input string req, input int sec, input int we0, input int b0);
        int errs = 0;
        chk(busy === 1'b1, {req, " busy after commit"}, int'(busy), 1);
        wait_idle();
        ticks(2);
        chk(we_tot - we0 == PAGE, {req, " array writes"}, we_tot - we0, PAGE);
        chk(busy_tot - b0 == PROG, {req, " busy length"}, busy_tot - b0, PROG);
        chk(cap_sec == sec, {req, " sector"}, cap_sec, sec);
        for (int i = 0; i < PAGE; i++) if (cap[i] !== ebuf[i]) errs++;
        chk(errs == 0, {req, " page contents mismatching bytes"}, errs, 0);
        chk(wel === 1'b0, {req, " R8 wel cleared"}, int'(wel), 0);
    endtask

    task automatic check_no_program(input string req, input int we0, input bit exp_wel);
        ticks(10);
        chk(busy === 1'b0, {req, " no busy"}, int'(busy), 0);
        chk(we_tot == we0, {req, " no array writes"}, we_tot - we0, 0);
        chk(wel === exp_wel, {req, " R8 wel kept"}, int'(wel), int'(exp_wel));
    endtask

    task automatic t_reset();
        chk(busy === 1'b0, "R11 busy at reset", int'(busy), 0);
        chk(wel === 1'b0, "R11 wel at reset", int'(wel), 0);
        chk(arr_we === 1'b0, "R11 arr_we at reset", int'(arr_we), 0);
    endtask

    task automatic t_full_page();
        int we0, b0;
        for (int i = 0; i < PAGE; i++) tx[i] = 8'((i * 7 + 3) & 255);
        pulse_wel();
        chk(wel === 1'b1, "R8 wel set by pulse", int'(wel), 1);
        we0 = we_tot; b0 = busy_tot;
        frame(8'hF3, 16'h0005, 16'h0000, 5, PAGE, 1, 0);
        model_load(0, PAGE);
        check_program("R1 R4 R9 full page", 5, we0, b0);
    endtask

    task automatic t_wrap();
        int we0, b0;
        for (int i = 0; i < 10; i++) tx[i] = 8'(8'hA0 + i);
        pulse_wel();
        we0 = we_tot; b0 = busy_tot;
        frame(8'hF3, 16'hFE0C, 16'h0104, 5, 10, 1, 0);
        model_load(260, 10);
        check_program("R2 R4 wrap past last column", 12, we0, b0);
        chk(cap[6] === 8'd45, "R5 control byte not stored", int'(cap[6]), 45);
    endtask

    task automatic t_wp_pin();
        int we0;
        tx[0] = 8'h11; tx[1] = 8'h22;
        pulse_wel();
        wp_n = 1'b0;
        we0 = we_tot;
        frame(8'hF3, 16'h0002, 16'h0020, 5, 2, 1, 0);
        model_load(32, 2);
        check_no_program("R7 wp_n low", we0, 1'b1);
        wp_n = 1'b1;
    endtask

    task automatic t_prot_window();
        int we0, b0;
        prot_lo = 9'h020; prot_hi = 9'h030;
        tx[0] = 8'h33;
        we0 = we_tot;
        frame(8'hF3, 16'h0030, 16'h0040, 5, 1, 1, 0);
        model_load(64, 1);
        check_no_program("R7 sector in protected window", we0, 1'b1);
        tx[0] = 8'h44;
        we0 = we_tot; b0 = busy_tot;
        frame(8'hF3, 16'h0031, 16'h0041, 5, 1, 1, 0);
        model_load(65, 1);
        check_program("R7 sector just above window", 49, we0, b0);
        prot_lo = 9'h1FF; prot_hi = 9'h000;
    endtask

    task automatic t_no_wel();
        int we0;
        tx[0] = 8'h55;
        we0 = we_tot;
        frame(8'hF3, 16'h0004, 16'h0050, 5, 1, 1, 0);
        model_load(80, 1);
        check_no_program("R7 no write enable", we0, 1'b0);
    endtask

    task automatic t_aborts();
        int we0, b0;
        pulse_wel();
        for (int i = 0; i < 3; i++) tx[i] = 8'(8'hE0 + i);
        we0 = we_tot;
        frame(8'h03, 16'h0004, 16'h0000, 5, 3, 1, 0);
        check_no_program("R1 wrong opcode", we0, 1'b1);
        frame(8'hF3, 16'h0004, 16'h0108, 5, 3, 1, 0);
        check_no_program("R3 column 108h", we0, 1'b1);
        tx[0] = 8'h66; tx[1] = 8'h77;
        frame(8'hF3, 16'h0004, 16'h0090, 5, 2, 1, 3);
        model_load(144, 2);
        check_no_program("R6 cs rise mid byte", we0, 1'b1);
        frame(8'hF3, 16'h0004, 16'h0000, 4, 0, 0, 0);
        check_no_program("R6 cs rise inside address", we0, 1'b1);
        we0 = we_tot; b0 = busy_tot;
        frame(8'hF3, 16'h0003, 16'h0000, 5, 0, 1, 0);
        check_program("R1 R3 R6 buffer after aborted frames", 3, we0, b0);
    endtask

    task automatic t_busy_ignore();
        int we0, b0, errs;
        for (int i = 0; i < 4; i++) tx[i] = 8'(8'h90 + i);
        pulse_wel();
        we0 = we_tot; b0 = busy_tot;
        frame(8'hF3, 16'h0009, 16'h0064, 5, 4, 1, 0);
        model_load(100, 4);
        chk(busy === 1'b1, "R10 busy after commit", int'(busy), 1);
        pulse_wel();
        chk(wel === 1'b0, "R8 wel_set ignored while busy", int'(wel), 0);
        tx[0] = 8'hCC; tx[1] = 8'hDD;
        frame(8'hF3, 16'h000A, 16'h0000, 5, 2, 1, 0);
        wait_idle();
        ticks(4);
        chk(we_tot - we0 == PAGE, "R10 only one program", we_tot - we0, PAGE);
        chk(cap_sec == 9, "R10 sector of first frame", cap_sec, 9);
        errs = 0;
        for (int i = 0; i < PAGE; i++) if (cap[i] !== ebuf[i]) errs++;
        chk(errs == 0, "R10 first page contents", errs, 0);
        pulse_wel();
        we0 = we_tot; b0 = busy_tot;
        frame(8'hF3, 16'h000A, 16'h0000, 5, 0, 1, 0);
        check_program("R10 buffer untouched by ignored frame", 10, we0, b0);
    endtask

    initial begin
        ticks(4);
        rst = 1'b0;
        ticks(2);
        t_reset();
        t_full_page();
        t_wrap();
        t_wp_pin();
        t_prot_window();
        t_no_wel();
        t_aborts();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule